// File: doc/BRIEF.md
# DCC Track Packet Transmitter

The block drives a two-phase model-railway command signal onto the track. It serialises a packet of one to six bytes. A binary one is sent as two short half-periods and a binary zero as two long half-periods. The line is high in the first half of every bit and low in the second. A half-bit counter, reloaded at each half boundary, sets the timing. Both half lengths are parameters in clock cycles.

A host loads the next packet into a staging buffer: the data bytes, a length and a long-preamble option. It may write only while `ready_o` is high. Inside the run of one bits that closes each packet and opens the next, the block withdraws `ready_o`. Twelve bits later it copies the staging buffer into its transmit buffer and raises `ready_o` again. If the host writes nothing, the same packet goes out in every frame.

The block also counts half-bits, with long halves counted twice, to produce a periodic tick strobe. On each tick it refreshes a track-enable output from the power request input.

Top module: `dcc_pkt_tx`

## Requirements
- R1: A one bit is a high half of ONE_HALF_CYC cycles followed by a low half of ONE_HALF_CYC cycles. A zero bit uses ZERO_HALF_CYC cycles for each half.
- R2: Output `track_o[i]` carries the line level when bit i of OUT_INVERT is 0, and its complement when that bit is 1.
- R3: Each packet byte is sent as one zero separator bit followed by its eight bits, most significant first. The bytes go out in index order.
- R4: After the last byte comes a run of one bits. The run is 14 bits long, or 24 bits when the transmit buffer's long-preamble option is set. The first bit of the run ends the packet, and the next packet's first separator follows the run.
- R5: `ready_o` falls on the edge that starts the second bit of the run. On the edge that starts the fourteenth bit, the staging buffer is copied into the transmit buffer and `ready_o` rises.
- R6: Without new host writes, every frame repeats the previous packet.
- R7: After reset the staging and transmit buffers both hold bytes 0xFF, 0x00, 0xFF, with length 3 and short preamble. `ready_o` is high, `tick_o` and `track_en_o` are low, and the line starts in the high half of the run's first bit.
- R8: Address 6 writes the control word. Bits [2:0] give the length, with 0 taken as 1 and 7 taken as 6. Bit [3] selects the long preamble. Addresses 0 to 5 write data bytes, and address 7 is ignored.
- R9: At each half boundary a counter adds 1 for a short half and 2 for a long half. When the sum reaches TICK_UNITS, the counter clears and `tick_o` pulses for one cycle.
- R10: `track_en_o` takes the value of `power_i` on each tick and holds it otherwise.
- R11: Writes presented while `ready_o` is low leave the staging buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Staging address: 0-5 data, 6 control |
| wr_data_i | input | 8 | Host write data |
| power_i | input | 1 | Track power request |
| ready_o | output | 1 | Staging buffer open for writes |
| track_o | output | NUM_OUT | Encoded line, per-output polarity |
| tick_o | output | 1 | Periodic one-cycle tick strobe |
| track_en_o | output | 1 | Track enable, refreshed per tick |

## Verification
The line level changes on the same rising edge that empties the half-bit counter. `ready_o`, the buffer copy and `tick_o` all change on that same boundary edge, with no extra cycle of latency. A host write is taken on the next rising edge, but it shows on the line only after the next copy inside the run. The bench advances its reference model on each rising edge and compares every output on the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/dcc_tx_pkg.sv
package dcc_tx_pkg;
  localparam int MAX_BYTES = 6;
  localparam int IDX_W = 3;
  localparam int RUN_W = 5;
  localparam logic [RUN_W-1:0] RUN_SHORT = RUN_W'(14);
  localparam logic [RUN_W-1:0] RUN_LONG = RUN_W'(24);
  localparam logic [RUN_W-1:0] HOLD_POS = RUN_W'(1);
  localparam logic [RUN_W-1:0] LOAD_POS = RUN_W'(13);
  localparam logic [IDX_W-1:0] CTRL_ADDR = IDX_W'(6);

  typedef enum logic [1:0] {SQ_RUN, SQ_SEP, SQ_DATA} sq_state_e;
  typedef logic [MAX_BYTES-1:0][7:0] pkt_bytes_t;

  function automatic logic [IDX_W-1:0] clamp_len(input logic [IDX_W-1:0] raw);
    if (raw == '0) return IDX_W'(1);
    if (raw > IDX_W'(MAX_BYTES)) return IDX_W'(MAX_BYTES);
    return raw;
  endfunction
endpackage

// File: rtl/dcc_half_timer.sv
module dcc_half_timer #(
  parameter int ONE_HALF_CYC  = 14500,
  parameter int ZERO_HALF_CYC = 29000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_bit_i,
  input  logic next_bit_i,
  output logic phase_low_o,
  output logic half_end_o
);
  localparam int CW = $clog2(ZERO_HALF_CYC + 1);
  localparam logic [CW-1:0] ONE_LOAD = CW'(ONE_HALF_CYC - 1);
  localparam logic [CW-1:0] ZERO_LOAD = CW'(ZERO_HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic low_q, low_d, sel_bit;

  assign half_end_o = (cnt_q == '0);
  assign phase_low_o = low_q;

  always_comb begin
    sel_bit = low_q ? next_bit_i : cur_bit_i;
    cnt_d = cnt_q - 1'b1;
    low_d = low_q;
    if (half_end_o) begin
      cnt_d = sel_bit ? ONE_LOAD : ZERO_LOAD;
      low_d = ~low_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ONE_LOAD;
      low_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      low_q <= low_d;
    end
  end
endmodule

// File: rtl/dcc_frame_seq.sv
module dcc_frame_seq
  import dcc_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_end_i,
  input  pkt_bytes_t       tx_data_i,
  input  logic [IDX_W-1:0] tx_len_i,
  input  logic             tx_long_i,
  output logic             cur_bit_o,
  output logic             next_bit_o,
  output logic             hold_o,
  output logic             load_o
);
  localparam logic [RUN_W-1:0] HOLD_PRE = HOLD_POS - 1'b1;
  localparam logic [RUN_W-1:0] LOAD_PRE = LOAD_POS - 1'b1;

  sq_state_e st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d, run_lim;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic [2:0] bit_q, bit_d;
  logic cur_q, nb;

  always_comb begin
    st_d = st_q;
    run_d = run_q;
    byte_d = byte_q;
    bit_d = bit_q;
    nb = 1'b1;
    run_lim = tx_long_i ? RUN_LONG : RUN_SHORT;
    unique case (st_q)
      SQ_RUN: begin
        if (run_q + 1'b1 < run_lim) begin
          run_d = run_q + 1'b1;
        end else begin
          st_d = SQ_SEP;
          byte_d = '0;
          nb = 1'b0;
        end
      end
      SQ_SEP: begin
        st_d = SQ_DATA;
        bit_d = 3'd7;
        nb = tx_data_i[byte_q][7];
      end
      SQ_DATA: begin
        if (bit_q != 3'd0) begin
          bit_d = bit_q - 1'b1;
          nb = tx_data_i[byte_q][bit_q - 1'b1];
        end else if (byte_q + 1'b1 < tx_len_i) begin
          st_d = SQ_SEP;
          byte_d = byte_q + 1'b1;
          nb = 1'b0;
        end else begin
          st_d = SQ_RUN;
          run_d = '0;
        end
      end
      default: st_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_RUN;
      run_q <= '0;
      byte_q <= '0;
      bit_q <= '0;
      cur_q <= 1'b1;
    end else if (bit_end_i) begin
      st_q <= st_d;
      run_q <= run_d;
      byte_q <= byte_d;
      bit_q <= bit_d;
      cur_q <= nb;
    end
  end

  assign cur_bit_o = cur_q;
  assign next_bit_o = nb;
  assign hold_o = bit_end_i && (st_q == SQ_RUN) && (run_q == HOLD_PRE);
  assign load_o = bit_end_i && (st_q == SQ_RUN) && (run_q == LOAD_PRE);
endmodule

// File: rtl/dcc_pkt_buf.sv
module dcc_pkt_buf
  import dcc_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             hold_i,
  input  logic             load_i,
  output logic             ready_o,
  output pkt_bytes_t       tx_data_o,
  output logic [IDX_W-1:0] tx_len_o,
  output logic             tx_long_o
);
  pkt_bytes_t stg_q, tx_q;
  logic [IDX_W-1:0] stg_len_q, tx_len_q;
  logic stg_long_q, tx_long_q, ready_q, ready_d;
  logic byte_we, ctrl_we;

  function automatic pkt_bytes_t idle_pkt();
    pkt_bytes_t p;
    for (int i = 0; i < MAX_BYTES; i++) p[i] = (i == 0 || i == 2) ? 8'hFF : 8'h00;
    return p;
  endfunction

  always_comb begin
    byte_we = wr_en_i && ready_q && (wr_addr_i < IDX_W'(MAX_BYTES));
    ctrl_we = wr_en_i && ready_q && (wr_addr_i == CTRL_ADDR);
    ready_d = ready_q;
    if (load_i) ready_d = 1'b1;
    else if (hold_i) ready_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= idle_pkt();
      stg_len_q <= IDX_W'(3);
      stg_long_q <= 1'b0;
    end else begin
      if (byte_we) stg_q[wr_addr_i] <= wr_data_i;
      if (ctrl_we) begin
        stg_len_q <= clamp_len(wr_data_i[IDX_W-1:0]);
        stg_long_q <= wr_data_i[3];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= idle_pkt();
      tx_len_q <= IDX_W'(3);
      tx_long_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      if (load_i) begin
        tx_q <= stg_q;
        tx_len_q <= stg_len_q;
        tx_long_q <= stg_long_q;
      end
      ready_q <= ready_d;
    end
  end

  assign ready_o = ready_q;
  assign tx_data_o = tx_q;
  assign tx_len_o = tx_len_q;
  assign tx_long_o = tx_long_q;
endmodule

// File: rtl/dcc_tick_gen.sv
module dcc_tick_gen #(
  parameter int TICK_UNITS = 172
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_end_i,
  input  logic zero_half_i,
  input  logic power_i,
  output logic tick_o,
  output logic track_en_o
);
  localparam int AW = $clog2(TICK_UNITS + 2);
  localparam logic [AW-1:0] LIMIT = AW'(TICK_UNITS);

  logic [AW-1:0] acc_q, acc_d, sum;
  logic tick_q, tick_d, en_q, en_d;

  always_comb begin
    sum = acc_q + (zero_half_i ? AW'(2) : AW'(1));
    acc_d = acc_q;
    tick_d = 1'b0;
    en_d = en_q;
    if (half_end_i) begin
      if (sum >= LIMIT) begin
        acc_d = '0;
        tick_d = 1'b1;
        en_d = power_i;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      tick_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick_q <= tick_d;
      en_q <= en_d;
    end
  end

  assign tick_o = tick_q;
  assign track_en_o = en_q;
endmodule

// File: rtl/dcc_pkt_tx.sv
module dcc_pkt_tx
  import dcc_tx_pkg::*;
#(
  parameter int ONE_HALF_CYC = 14500,
  parameter int ZERO_HALF_CYC = 29000,
  parameter int TICK_UNITS = 172,
  parameter int NUM_OUT = 2,
  parameter logic [NUM_OUT-1:0] OUT_INVERT = 2'b10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               power_i,
  output logic               ready_o,
  output logic [NUM_OUT-1:0] track_o,
  output logic               tick_o,
  output logic               track_en_o
);
  logic phase_low, half_end, bit_end, cur_bit, next_bit, hold, load, tx_long;
  pkt_bytes_t tx_data;
  logic [IDX_W-1:0] tx_len;

  assign bit_end = half_end & phase_low;

  dcc_half_timer #(.ONE_HALF_CYC(ONE_HALF_CYC), .ZERO_HALF_CYC(ZERO_HALF_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_bit_i(cur_bit), .next_bit_i(next_bit),
    .phase_low_o(phase_low), .half_end_o(half_end));

  dcc_frame_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_end_i(bit_end), .tx_data_i(tx_data),
    .tx_len_i(tx_len), .tx_long_i(tx_long), .cur_bit_o(cur_bit), .next_bit_o(next_bit),
    .hold_o(hold), .load_o(load));

  dcc_pkt_buf u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .hold_i(hold), .load_i(load), .ready_o(ready_o),
    .tx_data_o(tx_data), .tx_len_o(tx_len), .tx_long_o(tx_long));

  dcc_tick_gen #(.TICK_UNITS(TICK_UNITS)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_end_i(half_end), .zero_half_i(~cur_bit),
    .power_i(power_i), .tick_o(tick_o), .track_en_o(track_en_o));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign track_o[g] = (~phase_low) ^ OUT_INVERT[g];
  end
endmodule

// File: rtl/dcc_pkt_tx_chk.sv
module dcc_pkt_tx_chk #(
  parameter int ONE_HALF_CYC = 14500,
  parameter int ZERO_HALF_CYC = 29000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic phase_low,
  input logic half_end,
  input logic cur_bit,
  input logic ready_o,
  input logic tick_o,
  input logic track_en_o
);
  int hl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hl_cnt <= 0;
    else if (half_end) hl_cnt <= 0;
    else hl_cnt <= hl_cnt + 1;
  end

  AST_HALF_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_end |-> hl_cnt == (cur_bit ? ONE_HALF_CYC : ZERO_HALF_CYC) - 1); // R1
  AST_READY_FALL_AT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> ($fell(phase_low) && cur_bit)); // R5
  AST_READY_RISE_AT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($fell(phase_low) && cur_bit)); // R5
  AST_TICK_AFTER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(half_end)); // R9
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R9
  AST_EN_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(track_en_o) |-> tick_o); // R10
endmodule

bind dcc_pkt_tx dcc_pkt_tx_chk #(.ONE_HALF_CYC(ONE_HALF_CYC), .ZERO_HALF_CYC(ZERO_HALF_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase_low(phase_low), .half_end(half_end),
  .cur_bit(cur_bit), .ready_o(ready_o), .tick_o(tick_o), .track_en_o(track_en_o));

// File: tb/dcc_pkt_tx_tb_top.sv
module dcc_pkt_tx_tb_top;
  localparam int ONE = 4;
  localparam int ZERO = 8;
  localparam int TU = 50;
  localparam logic [1:0] INV = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic power = 1'b0;
  logic ready, tick, ten;
  logic [1:0] trk;

  always #2 clk = ~clk;

  dcc_pkt_tx #(.ONE_HALF_CYC(ONE), .ZERO_HALF_CYC(ZERO), .TICK_UNITS(TU),
               .NUM_OUT(2), .OUT_INVERT(INV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .power_i(power), .ready_o(ready), .track_o(trk),
    .tick_o(tick), .track_en_o(ten));

  int checks = 0;
  int fails = 0;
  string req_tag = "R6";
  bit cmp_on = 1'b0;
  int cyc = 0;

  // behavioural reference: queue of bit tags (0/1 data, 2 run bit, 3 run start)
  int m_cnt, m_low, m_bit, m_pos, m_acc;
  bit m_rdy, m_tick, m_en;
  int sdat[6], tdat[6];
  int slen, tlen;
  bit slong, tlong;
  int q[$];

  function automatic int hlen(int b);
    return (b != 0) ? ONE : ZERO;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 6; i++) begin
      sdat[i] = (i == 0 || i == 2) ? 255 : 0;
      tdat[i] = sdat[i];
    end
    slen = 3; tlen = 3; slong = 0; tlong = 0;
    m_cnt = ONE - 1; m_low = 0; m_bit = 1; m_pos = 0; m_acc = 0;
    m_rdy = 1; m_tick = 0; m_en = 0;
    q.delete();
    for (int i = 0; i < 13; i++) q.push_back(2);
  endfunction

  function automatic void m_push_frame();
    for (int i = 0; i < (tlong ? 10 : 0); i++) q.push_back(2);
    for (int b = 0; b < tlen; b++) begin
      q.push_back(0);
      for (int k = 7; k >= 0; k--) q.push_back((tdat[b] >> k) & 1);
    end
    q.push_back(3);
    for (int i = 0; i < 13; i++) q.push_back(2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      automatic bit he = (m_cnt == 0);
      automatic int t;
      automatic int v;
      if (wr_en && m_rdy) begin
        if (wr_addr < 6) sdat[wr_addr] = wr_data;
        else if (wr_addr == 6) begin
          v = wr_data & 7;
          if (v == 0) v = 1;
          if (v > 6) v = 6;
          slen = v;
          slong = wr_data[3];
        end
      end
      m_tick = 0;
      if (he) begin
        v = (m_bit != 0) ? 1 : 2;
        if (m_acc + v >= TU) begin m_acc = 0; m_tick = 1; m_en = power; end
        else m_acc = m_acc + v;
      end
      if (!he) m_cnt = m_cnt - 1;
      else if (m_low == 0) begin
        m_low = 1; m_cnt = hlen(m_bit) - 1;
      end else begin
        t = q.pop_front();
        m_bit = (t == 0) ? 0 : 1;
        m_low = 0;
        m_cnt = hlen(m_bit) - 1;
        if (t == 3) m_pos = 0;
        else if (t == 2) begin
          m_pos = m_pos + 1;
          if (m_pos == 1) m_rdy = 0;
          if (m_pos == 13) begin
            for (int i = 0; i < 6; i++) tdat[i] = sdat[i];
            tlen = slen; tlong = slong; m_rdy = 1;
            m_push_frame();
          end
        end else m_pos = -1;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk("R1 R2 R3 R4 track_o", int'(trk), int'({2{~m_low[0]}} ^ INV));
      chk("R5 R11 ready_o", int'(ready), int'(m_rdy));
      chk("R9 tick_o", int'(tick), int'(m_tick));
      chk("R10 track_en_o", int'(ten), int'(m_en));
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_rise();
    logic prev;
    prev = ready;
    @(negedge clk);
    while (!(ready && !prev)) begin
      prev = ready;
      @(negedge clk);
    end
  endtask

  task automatic wait_fall();
    logic prev;
    prev = ready;
    @(negedge clk);
    while (!(!ready && prev)) begin
      prev = ready;
      @(negedge clk);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req_tag = "R7";
    chk("R7 reset ready_o", int'(ready), 1);
    chk("R7 reset tick_o", int'(tick), 0);
    chk("R7 reset track_en_o", int'(ten), 0);
    chk("R7 reset track_o", int'(trk), int'(2'b11 ^ INV));
    rst_n = 1'b1;
    power = 1'b1;
    cmp_on = 1'b1;
    req_tag = "R6";
    repeat (2) wait_rise();
    // R3 R8: two-byte packet
    req_tag = "R3 R8";
    wait_rise();
    host_wr(3'd0, 8'hA5); host_wr(3'd1, 8'h3C); host_wr(3'd6, 8'h02);
    repeat (2) wait_rise();
    // R4: six bytes with long preamble
    req_tag = "R4";
    wait_rise();
    host_wr(3'd0, 8'h01); host_wr(3'd1, 8'h80); host_wr(3'd2, 8'h7E);
    host_wr(3'd3, 8'hC3); host_wr(3'd4, 8'h00); host_wr(3'd5, 8'hFF);
    host_wr(3'd7, 8'h01); host_wr(3'd6, 8'h0E);
    repeat (2) wait_rise();
    // R8: length clamps
    req_tag = "R8";
    wait_rise();
    host_wr(3'd6, 8'h00);
    repeat (2) wait_rise();
    host_wr(3'd6, 8'h07);
    repeat (2) wait_rise();
    // R11: writes while ready is low
    req_tag = "R11";
    wait_fall();
    host_wr(3'd0, 8'h55); host_wr(3'd6, 8'h01);
    repeat (3) wait_rise();
    // R10: power request toggling
    req_tag = "R10";
    power = 1'b0;
    repeat (3) wait_rise();
    power = 1'b1;
    repeat (2) wait_rise();
    req_tag = "R6";
    repeat (2) wait_rise();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule